// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block turns a short list of message descriptors into the exact sequence of bus operations a bit-level I2C engine must perform for one controller-side transaction to a single 7-bit target. Each descriptor gives a direction, a byte length, a restart flag and a stop flag. The sequencer decides where start, repeated-start and stop conditions go. It inserts the address byte after each start, moves write bytes from an input stream to the engine, and hands received bytes to an output stream. When the transaction finishes, it reports success or a NACK error.

Software first loads the descriptors into a small table through a write port. It then issues a command that carries the message count and the target address. The engine is controlled through a level request with an operation code. The engine answers with a one-cycle completion pulse, the acknowledge it sampled, and any received byte. Line timing, clock stretching and 10-bit addressing belong to the engine or are not handled.

Top module: `i2c_txn_seq`

## Requirements
- R1: A command with a message count of zero raises `done_o` in the cycle after it is accepted, clears `err_o`, and makes no engine request.
- R2: Every non-empty transaction begins with a STOP operation, then a START, then the address byte. The engine operation codes are START=1, RSTART=2, STOP=3, WRITE=4 and READ=5.
- R3: The address byte is the 7-bit target address in bits 7:1, with bit 0 equal to 1 for a read message and 0 for a write message.
- R4: When the previous message had its stop flag set, the next message is preceded by a STOP and then a full START with a new address byte.
- R5: When the previous message had no stop flag, a message with its restart flag set is preceded by an RSTART and a new address byte. A message with its restart flag clear continues with data only: no condition and no address byte.
- R6: A NACK (`eng_ack_i`=0) on the address byte or on any write byte is followed at once by a STOP. No further message operations are issued, and `err_o` is set to 1.
- R7: Each READ operation drives `eng_ack_out_o`=0 (acknowledge), except the last byte of the message, which drives 1 (not acknowledged).
- R8: Write bytes are taken from the write stream in order, one per completed data WRITE. Received bytes appear on `rd_data_o` with a `rd_valid_o` pulse, in order.
- R9: Every transaction ends with a STOP, after which `done_o` pulses. `err_o` is 0 if no NACK occurred.
- R10: `err_o` keeps its value while idle and is cleared only when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Write one descriptor entry |
| desc_idx_i | input | IDX_W | Descriptor entry index |
| desc_rd_i | input | 1 | Message direction, 1 = read |
| desc_len_i | input | LEN_W | Message length in bytes |
| desc_rs_i | input | 1 | Restart flag of the message |
| desc_st_i | input | 1 | Stop-after flag of the message |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted |
| cmd_count_i | input | CNT_W | Number of messages |
| cmd_addr_i | input | 7 | Target address |
| wr_data_i | input | 8 | Write stream byte |
| wr_valid_i | input | 1 | Write stream byte available |
| wr_ready_o | output | 1 | Write stream byte consumed |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Received byte strobe |
| eng_req_o | output | 1 | Engine operation request (level) |
| eng_op_o | output | 3 | Engine operation code |
| eng_data_o | output | 8 | Byte to transmit |
| eng_ack_out_o | output | 1 | Acknowledge level for a read (0 = ACK) |
| eng_done_i | input | 1 | Engine operation complete (pulse) |
| eng_ack_i | input | 1 | Acknowledge sampled on a write, 1 = ACK |
| eng_rd_data_i | input | 8 | Byte received by the engine |
| done_o | output | 1 | Transaction finished (pulse) |
| err_o | output | 1 | Last transaction ended on a NACK |

## Verification
The bench compares the whole engine operation log of each transaction against a list it builds from the descriptors. This shows up a sequencer that sends an address after a message with its restart flag clear, that uses a repeated start where a stop came first, or that skips the opening stop. Length-zero messages, back-to-back messages with no conditions, and single-byte reads are targeted. A wrong design there would loop, emit a stray READ, or acknowledge the final read byte. NACKs are injected on the address byte and on mid-message data. A design that does not abort would keep issuing operations and consuming write bytes. The bench also checks that the error flag survives idle cycles and clears only on the next accepted command.

// File: rtl/i2c_txn_seq_pkg.sv
`timescale 1ns/1ps
package i2c_txn_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_START = 3'd1, OP_RSTART = 3'd2,
    OP_STOP = 3'd3, OP_WRITE = 3'd4, OP_READ = 3'd5
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_START, S_RSTART, S_ADDR,
    S_DATA, S_EOM, S_ADV, S_MID, S_FIN
  } seq_state_e;
endpackage

// File: rtl/i2c_txn_desc_tbl.sv
`timescale 1ns/1ps
module i2c_txn_desc_tbl #(
  parameter int N     = 8,
  parameter int LEN_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wrd_i,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic             wrs_i,
  input  logic             wst_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic             rd_o,
  output logic [LEN_W-1:0] len_o,
  output logic             rs_o,
  output logic             st_o
);
  localparam int EW = LEN_W + 3;
  logic [EW-1:0] ent_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g)) ent_q[g] <= {wrd_i, wrs_i, wst_i, wlen_i};
    end
  end

  assign {rd_o, rs_o, st_o, len_o} = ent_q[ridx_i];
endmodule

// File: rtl/i2c_txn_byte_cnt.sv
`timescale 1ns/1ps
module i2c_txn_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] len_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q + 1'b1) == len_i;
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
  import i2c_txn_seq_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  localparam int IDX_W   = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1,
  localparam int CNT_W   = $clog2(MAX_MSGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_we_i,
  input  logic [IDX_W-1:0] desc_idx_i,
  input  logic             desc_rd_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             desc_rs_i,
  input  logic             desc_st_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [CNT_W-1:0] cmd_count_i,
  input  logic [6:0]       cmd_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             eng_req_o,
  output logic [2:0]       eng_op_o,
  output logic [7:0]       eng_data_o,
  output logic             eng_ack_out_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rd_data_i,
  output logic             done_o,
  output logic             err_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] count_q;
  logic [6:0]       addr_q;
  logic             err_q, done_q;
  logic             m_rd, m_rs, m_st, last;
  logic [LEN_W-1:0] m_len;
  eng_op_e          op;
  logic             step, accept, is_last_msg;

  i2c_txn_desc_tbl #(.N(MAX_MSGS), .LEN_W(LEN_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(desc_we_i), .widx_i(desc_idx_i), .wrd_i(desc_rd_i),
    .wlen_i(desc_len_i), .wrs_i(desc_rs_i), .wst_i(desc_st_i),
    .ridx_i(idx_q), .rd_o(m_rd), .len_o(m_len), .rs_o(m_rs), .st_o(m_st)
  );

  i2c_txn_byte_cnt #(.W(LEN_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(state_q != S_DATA),
    .inc_i(step && state_q == S_DATA && !last),
    .len_i(m_len), .last_o(last)
  );

  always_comb begin
    unique case (state_q)
      S_PRE, S_MID, S_FIN: op = OP_STOP;
      S_START:             op = OP_START;
      S_RSTART:            op = OP_RSTART;
      S_ADDR:              op = OP_WRITE;
      S_DATA:              op = m_rd ? OP_READ : OP_WRITE;
      default:             op = OP_NONE;
    endcase
  end

  assign eng_op_o      = op;
  assign eng_req_o     = (op != OP_NONE) && !(state_q == S_DATA && !m_rd && !wr_valid_i);
  assign eng_data_o    = (state_q == S_ADDR) ? {addr_q, m_rd} : wr_data_i;
  assign eng_ack_out_o = (state_q == S_DATA) && m_rd && last;
  assign step          = eng_req_o && eng_done_i;
  assign wr_ready_o    = step && state_q == S_DATA && !m_rd;
  assign rd_valid_o    = step && state_q == S_DATA && m_rd;
  assign rd_data_o     = eng_rd_data_i;
  assign cmd_ready_o   = state_q == S_IDLE;
  assign accept        = cmd_valid_i && cmd_ready_o;
  assign is_last_msg   = (CNT_W'(idx_q) + 1'b1) == count_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept && cmd_count_i != '0) state_d = S_PRE;
      S_PRE:    if (step) state_d = S_START;
      S_START,
      S_RSTART: if (step) state_d = S_ADDR;
      S_ADDR:   if (step) state_d = !eng_ack_i ? S_FIN : (m_len == '0) ? S_EOM : S_DATA;
      S_DATA:   if (step) begin
                  if (!m_rd && !eng_ack_i) state_d = S_FIN;
                  else if (last)           state_d = S_EOM;
                end
      S_EOM:    state_d = is_last_msg ? S_FIN : (m_st ? S_MID : S_ADV);
      S_ADV:    state_d = m_rs ? S_RSTART : (m_len == '0) ? S_EOM : S_DATA;
      S_MID:    if (step) state_d = S_START;
      S_FIN:    if (step) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      count_q <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (accept && cmd_count_i == '0) || (state_q == S_FIN && step);
      if (accept) begin
        idx_q   <= '0;
        count_q <= cmd_count_i;
        addr_q  <= cmd_addr_i;
        err_q   <= 1'b0;
      end
      if (step && !eng_ack_i && (state_q == S_ADDR || (state_q == S_DATA && !m_rd)))
        err_q <= 1'b1;
      if (state_q == S_EOM && !is_last_msg) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_txn_seq_chk.sv
`timescale 1ns/1ps
module i2c_txn_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic       rd_valid_o,
  input logic       eng_req_o,
  input logic [2:0] eng_op_o,
  input logic       eng_done_i,
  input logic       eng_ack_i,
  input logic       done_o,
  input logic       err_o
);
  assert_idle_no_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !eng_req_o);

  assert_nack_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_done_i && eng_op_o == 3'd4 && !eng_ack_i) |=> (eng_op_o == 3'd3));

  assert_err_rise_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (eng_op_o == 3'd3 && !cmd_ready_o));

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  assert_err_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && !cmd_valid_i) |=> $stable(err_o));

  assert_wr_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> (wr_valid_i && eng_done_i && eng_op_o == 3'd4));

  assert_rd_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (eng_done_i && eng_op_o == 3'd5));
endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .wr_valid_i, .wr_ready_o,
  .rd_valid_o, .eng_req_o, .eng_op_o, .eng_done_i, .eng_ack_i, .done_o, .err_o
);

// File: tb/i2c_txn_seq_tb.sv
`timescale 1ns/100ps
module i2c_txn_seq_tb;
  localparam int MAXM = 8;
  localparam int LW = 8;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic desc_we = 0, desc_rd = 0, desc_rs = 0, desc_st = 0;
  logic [2:0] desc_idx = 0;
  logic [LW-1:0] desc_len = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [3:0] cmd_count = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, eng_data, eng_rd_data = 0;
  logic wr_valid = 0, wr_ready, rd_valid, eng_req, eng_ack_out;
  logic [2:0] eng_op;
  logic eng_done = 0, eng_ack = 1, done, err;

  i2c_txn_seq #(.MAX_MSGS(MAXM), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_we_i(desc_we), .desc_idx_i(desc_idx), .desc_rd_i(desc_rd),
    .desc_len_i(desc_len), .desc_rs_i(desc_rs), .desc_st_i(desc_st),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_count_i(cmd_count),
    .cmd_addr_i(cmd_addr), .wr_data_i(wr_data), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_data_o(eng_data),
    .eng_ack_out_o(eng_ack_out), .eng_done_i(eng_done), .eng_ack_i(eng_ack),
    .eng_rd_data_i(eng_rd_data), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transaction description
  bit t_rd[MAXM], t_rs[MAXM], t_st[MAXM];
  int t_len[MAXM];
  logic [7:0] wbytes[64];
  int nack_at;

  // engine model log
  logic [11:0] act_ops[256];
  int act_n, eng_wc, eng_rc, dly;
  logic [7:0] rd_cap[64];
  int rd_n, wptr, wtotal;
  bit take;

  // expected
  logic [11:0] exp_ops[256];
  int exp_n, exp_dw, exp_rd;
  bit exp_err;

  task automatic push(logic [2:0] op, logic ao, logic [7:0] d);
    exp_ops[exp_n] = {op, ao, d};
    exp_n++;
  endtask

  task automatic build_exp(int n, logic [6:0] a);
    int wi, wc;
    bit ab, da;
    exp_n = 0; exp_dw = 0; exp_rd = 0; exp_err = 0;
    wi = 0; wc = 0; ab = 0;
    if (n == 0) return;
    for (int i = 0; i < n; i++) begin
      if (ab) break;
      da = 0;
      if (i == 0 || t_st[i-1]) begin push(3, 0, 0); push(1, 0, 0); da = 1; end
      else if (t_rs[i]) begin push(2, 0, 0); da = 1; end
      if (da) begin
        push(4, 0, {a, t_rd[i]});
        if (wc == nack_at) ab = 1;
        wc++;
      end
      for (int b = 0; b < t_len[i] && !ab; b++) begin
        if (t_rd[i]) begin push(5, (b == t_len[i]-1), 0); exp_rd++; end
        else begin
          push(4, 0, wbytes[wi]); wi++; exp_dw++;
          if (wc == nack_at) ab = 1;
          wc++;
        end
      end
    end
    push(3, 0, 0);
    exp_err = ab;
  endtask

  // engine model
  initial forever begin
    @(negedge clk); #0.5;
    if (eng_done) eng_done = 0;
    else if (eng_req) begin
      if (dly > 0) dly--;
      else begin
        eng_ack = 1;
        if (eng_op == 3'd4) begin
          act_ops[act_n] = {eng_op, 1'b0, eng_data};
          eng_ack = (eng_wc != nack_at);
          eng_wc++;
        end else if (eng_op == 3'd5) begin
          act_ops[act_n] = {eng_op, eng_ack_out, 8'h00};
          eng_rd_data = 8'((eng_rc * 37 + 5) & 255);
          eng_rc++;
        end else act_ops[act_n] = {eng_op, 9'h000};
        if (act_n < 255) act_n++;
        eng_done = 1;
        dly = $urandom % 3;
      end
    end
  end

  // write feeder and read capture
  initial forever begin
    @(negedge clk); #0.2;
    if (take) wptr++;
    take = 0;
    wr_valid = (wptr < wtotal);
    wr_data = wbytes[wptr % 64];
    #0.5;
    take = wr_ready && wr_valid;
    if (rd_valid && rd_n < 64) begin rd_cap[rd_n] = rd_data; rd_n++; end
  end

  task automatic load(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      desc_we = 1; desc_idx = 3'(i); desc_rd = t_rd[i];
      desc_len = LW'(t_len[i]); desc_rs = t_rs[i]; desc_st = t_st[i];
    end
    @(negedge clk); desc_we = 0;
  endtask

  task automatic run(int n, logic [6:0] a, string tag);
    int cyc;
    load(n);
    for (int k = 0; k < 64; k++) wbytes[k] = 8'($urandom);
    act_n = 0; eng_wc = 0; eng_rc = 0; rd_n = 0; wptr = 0; dly = 0; take = 0;
    build_exp(n, a);
    wtotal = exp_dw + (nack_at >= 0 ? 1 : 0);
    @(negedge clk);
    cmd_valid = 1; cmd_count = 4'(n); cmd_addr = a;
    @(negedge clk); cmd_valid = 0;
    #0.7;
    // R10: accepted command clears the held error
    chk(err == 0 || exp_err, "R10 err cleared on accept", err, 0);
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); #0.7; cyc++; end
    chk(cyc < 3000, {tag, " R9 done timeout"}, cyc, 0);
    if (n == 0) chk(cyc == 0 && act_n == 0, "R1 zero count immediate, no ops", act_n, 0);
    chk(act_n == exp_n, {tag, " R2/R4/R5 op count"}, act_n, exp_n);
    for (int i = 0; i < exp_n && i < act_n; i++)
      chk(act_ops[i] == exp_ops[i], {tag, " R2 R3 R4 R5 R6 R7 op"}, act_ops[i], exp_ops[i]);
    chk(err == exp_err, {tag, " R6 R9 err"}, err, exp_err);
    chk(rd_n == exp_rd, {tag, " R8 read count"}, rd_n, exp_rd);
    for (int i = 0; i < rd_n; i++)
      chk(rd_cap[i] == 8'((i * 37 + 5) & 255), {tag, " R8 read data"}, rd_cap[i], (i*37+5)&255);
    chk(wptr == exp_dw || exp_err, {tag, " R8 write consumed"}, wptr, exp_dw);
  endtask

  initial begin
    int w;
    w = 0;
    while (w < 150000) begin @(posedge clk); w++; end
    chk(0, "watchdog", w, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1c2a));
    #9 rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !eng_req && !err && !done, "R1 reset state", {cmd_ready, eng_req, err, done}, 4'b1000);

    // directed: zero count
    nack_at = -1;
    run(0, 7'h11, "zero");

    // directed: write then repeated-start read (R3 R5 R7)
    t_rd[0] = 0; t_len[0] = 2; t_rs[0] = 0; t_st[0] = 0;
    t_rd[1] = 1; t_len[1] = 3; t_rs[1] = 1; t_st[1] = 0;
    run(2, 7'h50, "wr_rs_rd");

    // directed: stop between, no-restart continuation, empty and 1-byte read (R4 R5 R7)
    t_rd[0] = 0; t_len[0] = 1; t_rs[0] = 0; t_st[0] = 1;
    t_rd[1] = 1; t_len[1] = 1; t_rs[1] = 0; t_st[1] = 0;
    t_rd[2] = 1; t_len[2] = 0; t_rs[2] = 0; t_st[2] = 0;
    t_rd[3] = 1; t_len[3] = 2; t_rs[3] = 0; t_st[3] = 0;
    run(4, 7'h2a, "stop_mix");

    // directed: NACK on address (R6), then hold check (R10)
    t_rd[0] = 0; t_len[0] = 3; t_rs[0] = 0; t_st[0] = 0;
    nack_at = 0;
    run(1, 7'h7f, "nack_addr");
    repeat (5) @(negedge clk);
    #0.7 chk(err == 1, "R10 err held while idle", err, 1);

    // directed: NACK on a middle write byte (R6)
    nack_at = 2;
    t_len[0] = 4;
    t_rd[1] = 1; t_len[1] = 2; t_rs[1] = 1; t_st[1] = 1;
    run(2, 7'h33, "nack_data");

    // random
    for (int t = 0; t < 60; t++) begin
      int n;
      n = 1 + ($urandom % MAXM);
      for (int i = 0; i < n; i++) begin
        t_rd[i] = $urandom % 2; t_len[i] = $urandom % 5;
        t_rs[i] = $urandom % 2; t_st[i] = $urandom % 2;
      end
      nack_at = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
      run(n, 7'($urandom), "rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule